// File: doc/BRIEF.md
# Vectored Interrupt Request Controller

This block gathers a set of level-sensitive interrupt lines and turns them into a single request wire and a vector number for a processor core. Each line is sampled into a raw status register on every clock. The raw status is gated by a software-programmed enable mask, and the result is kept in a masked status register. When exactly one enabled line is active, the vector names that line. When two or more are active, the vector takes one shared value, and the interrupt handler reads the masked status to decide which source to serve first.

Software reaches five 32-bit registers through a simple register bus that decodes only full-word accesses. The enable mask, a non-maskable-interrupt word and a fault word can be written. The raw and masked status words can only be read. An access to an offset that is not decoded returns an error pulse and changes nothing. All outputs are registered, so the request and the vector change on the clock edge that captures a line change or a mask write.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset every register reads 0, and `irq_req`, `irq_vec` and `bus_err` are 0.
- R2: At each clock edge the raw status word (offset 0x4) captures the level of every interrupt line: bit i is 1 when line i is high and 0 when it is low. Bits above the line count read 0.
- R3: The masked status word (offset 0x8) always equals the raw status ANDed with the enable mask, and it updates on the same edge as the raw status or the mask.
- R4: When exactly one masked bit i is set, `irq_req` is 1 and `irq_vec` is 0x31 + i.
- R5: When two or more masked bits are set, `irq_req` is 1 and `irq_vec` is 0x30.
- R6: When no masked bit is set, `irq_req` is 0 and `irq_vec` is 0.
- R7: A word write to the enable mask (offset 0x0) stores all 32 bits, and the masked status, `irq_req` and `irq_vec` reflect the new mask on the same clock edge.
- R8: The non-maskable-interrupt word (offset 0xC) and the fault word (offset 0x10) store any 32-bit value written to them, read it back, and have no effect on `irq_req` or `irq_vec`.
- R9: Word writes to the raw status (0x4) or the masked status (0x8) are ignored.
- R10: Only accesses with `bus_size` = 2 (word) are decoded. A byte (0) or halfword (1) read returns 0, and a byte or halfword write changes no register.
- R11: An access to any offset other than 0x0, 0x4, 0x8, 0xC or 0x10 sets `bus_err` for exactly the following cycle, returns read data 0 and leaves every register unchanged.
- R12: Read data appears on `bus_rdata` in the cycle after the read is presented, and is 0 in any cycle that follows no decoded word read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines | input | NUM_LINES | Level-sensitive interrupt lines |
| bus_valid | input | 1 | Register access strobe for one cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| bus_err | output | 1 | One-cycle error for an undecoded offset |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | VEC_W | Vector number for the request |

## Verification
On every cycle the assertions check that the masked status stays equal to raw AND mask, that the raw status follows the lines of the previous cycle, and that the request and vector agree with the number of masked bits (none, one or several). They also check that error pulses come only from undecoded offsets and leave the mask unchanged, and that narrow writes never move the mask. Only the directed scenarios can show that read data comes back at the right offsets, that NMI and fault words keep their stored values, and that writes to the status words have no effect.

// File: rtl/irqv_pkg.sv
package irqv_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  typedef enum logic [2:0] {
    SEL_MASK   = 3'd0,
    SEL_RAW    = 3'd1,
    SEL_MASKED = 3'd2,
    SEL_NMI    = 3'd3,
    SEL_FAULT  = 3'd4,
    SEL_NONE   = 3'd7
  } reg_sel_e;

  localparam int OFF_MASK   = 'h00;
  localparam int OFF_RAW    = 'h04;
  localparam int OFF_MASKED = 'h08;
  localparam int OFF_NMI    = 'h0C;
  localparam int OFF_FAULT  = 'h10;

endpackage

// File: rtl/irqv_decode.sv
module irqv_decode
  import irqv_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel,
  output logic              bad
);

  always_comb begin
    sel = SEL_NONE;
    if      (addr == ADDR_W'(OFF_MASK))   sel = SEL_MASK;
    else if (addr == ADDR_W'(OFF_RAW))    sel = SEL_RAW;
    else if (addr == ADDR_W'(OFF_MASKED)) sel = SEL_MASKED;
    else if (addr == ADDR_W'(OFF_NMI))    sel = SEL_NMI;
    else if (addr == ADDR_W'(OFF_FAULT))  sel = SEL_FAULT;
    bad = (sel == SEL_NONE);
  end

endmodule

// File: rtl/irqv_regbank.sv
module irqv_regbank
  import irqv_pkg::*;
#(
  parameter int NUM_LINES = 30,
  parameter int DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 acc_valid,
  input  logic                 acc_write,
  input  logic [1:0]           acc_size,
  input  logic [DATA_W-1:0]    acc_wdata,
  input  reg_sel_e             sel,
  input  logic                 bad,
  input  logic [NUM_LINES-1:0] lines,
  output logic [DATA_W-1:0]    raw_q,
  output logic [DATA_W-1:0]    mask_q,
  output logic [DATA_W-1:0]    masked_q,
  output logic [DATA_W-1:0]    nmi_q,
  output logic [DATA_W-1:0]    fault_q,
  output logic [DATA_W-1:0]    masked_nxt,
  output logic [DATA_W-1:0]    rdata_q,
  output logic                 err_q
);

  logic              word_ok;
  logic              wr_en;
  logic              rd_en;
  logic [DATA_W-1:0] mask_nxt;
  logic [DATA_W-1:0] raw_nxt;
  logic [DATA_W-1:0] rd_mux;

  assign word_ok = acc_valid && !bad && (acc_size == SZ_WORD);
  assign wr_en   = word_ok && acc_write;
  assign rd_en   = word_ok && !acc_write;

  assign mask_nxt   = (wr_en && sel == SEL_MASK) ? acc_wdata : mask_q;
  assign raw_nxt    = DATA_W'(lines);
  assign masked_nxt = raw_nxt & mask_nxt;

  always_comb begin
    case (sel)
      SEL_MASK:   rd_mux = mask_q;
      SEL_RAW:    rd_mux = raw_q;
      SEL_MASKED: rd_mux = masked_q;
      SEL_NMI:    rd_mux = nmi_q;
      SEL_FAULT:  rd_mux = fault_q;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q    <= '0;
      mask_q   <= '0;
      masked_q <= '0;
      nmi_q    <= '0;
      fault_q  <= '0;
      rdata_q  <= '0;
      err_q    <= 1'b0;
    end else begin
      raw_q    <= raw_nxt;
      mask_q   <= mask_nxt;
      masked_q <= masked_nxt;
      if (wr_en && sel == SEL_NMI)   nmi_q   <= acc_wdata;
      if (wr_en && sel == SEL_FAULT) fault_q <= acc_wdata;
      rdata_q  <= rd_en ? rd_mux : '0;
      err_q    <= acc_valid && bad;
    end
  end

endmodule

// File: rtl/irqv_encode.sv
module irqv_encode #(
  parameter int NUM_LINES  = 30,
  parameter int DATA_W     = 32,
  parameter int VEC_W      = 8,
  parameter int VEC_SHARED = 'h30,
  parameter int VEC_BASE   = 'h31
) (
  input  logic [DATA_W-1:0] masked,
  output logic              any,
  output logic [VEC_W-1:0]  vec
);

  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

  logic [NUM_LINES-1:0] m;
  logic [IDX_W-1:0]     idx;
  logic                 found;
  logic                 multi;

  assign m = masked[NUM_LINES-1:0];

  always_comb begin
    idx   = '0;
    found = 1'b0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (!found && m[i]) begin
        idx   = IDX_W'(i);
        found = 1'b1;
      end
    end
    any   = |m;
    multi = |(m & (m - 1'b1));
    if (!any)       vec = '0;
    else if (multi) vec = VEC_W'(VEC_SHARED);
    else            vec = VEC_W'(VEC_BASE) + VEC_W'(idx);
  end

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irqv_pkg::*;
#(
  parameter int NUM_LINES  = 30,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 8,
  parameter int VEC_W      = 8,
  parameter int VEC_SHARED = 'h30,
  parameter int VEC_BASE   = 'h31
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] irq_lines,
  input  logic                 bus_valid,
  input  logic                 bus_write,
  input  logic [1:0]           bus_size,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  output logic                 bus_err,
  output logic                 irq_req,
  output logic [VEC_W-1:0]     irq_vec
);

  reg_sel_e          sel;
  logic              bad;
  logic [DATA_W-1:0] raw_q;
  logic [DATA_W-1:0] mask_q;
  logic [DATA_W-1:0] masked_q;
  logic [DATA_W-1:0] nmi_q;
  logic [DATA_W-1:0] fault_q;
  logic [DATA_W-1:0] masked_nxt;
  logic              any_nxt;
  logic [VEC_W-1:0]  vec_nxt;

  irqv_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .sel  (sel),
    .bad  (bad)
  );

  irqv_regbank #(.NUM_LINES(NUM_LINES), .DATA_W(DATA_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .acc_valid  (bus_valid),
    .acc_write  (bus_write),
    .acc_size   (bus_size),
    .acc_wdata  (bus_wdata),
    .sel        (sel),
    .bad        (bad),
    .lines      (irq_lines),
    .raw_q      (raw_q),
    .mask_q     (mask_q),
    .masked_q   (masked_q),
    .nmi_q      (nmi_q),
    .fault_q    (fault_q),
    .masked_nxt (masked_nxt),
    .rdata_q    (bus_rdata),
    .err_q      (bus_err)
  );

  irqv_encode #(
    .NUM_LINES(NUM_LINES), .DATA_W(DATA_W), .VEC_W(VEC_W),
    .VEC_SHARED(VEC_SHARED), .VEC_BASE(VEC_BASE)
  ) u_enc (
    .masked (masked_nxt),
    .any    (any_nxt),
    .vec    (vec_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req <= 1'b0;
      irq_vec <= '0;
    end else begin
      irq_req <= any_nxt;
      irq_vec <= vec_nxt;
    end
  end

endmodule

// File: rtl/irqv_checker.sv
module irqv_checker #(
  parameter int NUM_LINES  = 30,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 8,
  parameter int VEC_W      = 8,
  parameter int VEC_SHARED = 'h30,
  parameter int VEC_BASE   = 'h31
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NUM_LINES-1:0] irq_lines,
  input logic                 bus_valid,
  input logic                 bus_write,
  input logic [1:0]           bus_size,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic                 bus_err,
  input logic                 irq_req,
  input logic [VEC_W-1:0]     irq_vec,
  input logic [DATA_W-1:0]    raw_q,
  input logic [DATA_W-1:0]    mask_q,
  input logic [DATA_W-1:0]    masked_q
);

  logic undecoded;
  assign undecoded = !(bus_addr == ADDR_W'('h00) || bus_addr == ADDR_W'('h04) ||
                       bus_addr == ADDR_W'('h08) || bus_addr == ADDR_W'('h0C) ||
                       bus_addr == ADDR_W'('h10));

  a_r2_raw_follows: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> raw_q == DATA_W'($past(irq_lines)));

  a_r3_masked_and: assert property (@(posedge clk) disable iff (rst)
    masked_q == (raw_q & mask_q));

  a_r4_single_vec: assert property (@(posedge clk) disable iff (rst)
    $countones(masked_q) == 1 |->
      irq_req && (((masked_q >> (irq_vec - VEC_W'(VEC_BASE))) & DATA_W'(1)) != '0));

  a_r5_shared_vec: assert property (@(posedge clk) disable iff (rst)
    $countones(masked_q) > 1 |-> irq_req && irq_vec == VEC_W'(VEC_SHARED));

  a_r6_idle: assert property (@(posedge clk) disable iff (rst)
    masked_q == '0 |-> !irq_req && irq_vec == '0);

  a_r10_narrow_write: assert property (@(posedge clk) disable iff (rst)
    bus_valid && bus_write && bus_size != 2'd2 |=> $stable(mask_q));

  a_r11_err_source: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && bus_err |-> $past(bus_valid) && $past(undecoded));

  a_r11_err_no_change: assert property (@(posedge clk) disable iff (rst)
    bus_valid && undecoded |=> bus_err && $stable(mask_q));

endmodule

bind irq_vector_ctrl irqv_checker #(
  .NUM_LINES(NUM_LINES), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .VEC_W(VEC_W),
  .VEC_SHARED(VEC_SHARED), .VEC_BASE(VEC_BASE)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .irq_lines (irq_lines),
  .bus_valid (bus_valid),
  .bus_write (bus_write),
  .bus_size  (bus_size),
  .bus_addr  (bus_addr),
  .bus_err   (bus_err),
  .irq_req   (irq_req),
  .irq_vec   (irq_vec),
  .raw_q     (raw_q),
  .mask_q    (mask_q),
  .masked_q  (masked_q)
);

// File: tb/irq_vector_ctrl_tb.sv
`timescale 1ns/1ps
module irq_vector_ctrl_tb;

  localparam int NL = 30;
  localparam int DW = 32;
  localparam int AW = 8;
  localparam int VW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NL-1:0] irq_lines = '0;
  logic          bus_valid = 1'b0;
  logic          bus_write = 1'b0;
  logic [1:0]    bus_size  = 2'd2;
  logic [AW-1:0] bus_addr  = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          bus_err;
  logic          irq_req;
  logic [VW-1:0] irq_vec;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  irq_vector_ctrl u_dut (
    .clk(clk), .rst(rst), .irq_lines(irq_lines),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_size(bus_size),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .irq_req(irq_req), .irq_vec(irq_vec)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      checks = checks + 1;
      errors = errors + 1;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic bus_acc(input logic wr, input logic [1:0] sz, input logic [AW-1:0] a,
                         input logic [DW-1:0] wd, output logic [DW-1:0] rd, output logic er);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = wr; bus_size = sz; bus_addr = a; bus_wdata = wd;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0; bus_size = 2'd2;
    rd = bus_rdata; er = bus_err;
  endtask

  task automatic wr32(input logic [AW-1:0] a, input logic [DW-1:0] d);
    logic [DW-1:0] rd; logic er;
    bus_acc(1'b1, 2'd2, a, d, rd, er);
  endtask

  task automatic rd32(input logic [AW-1:0] a, output logic [DW-1:0] d);
    logic er;
    bus_acc(1'b0, 2'd2, a, '0, d, er);
  endtask

  task automatic set_lines(input logic [NL-1:0] v);
    @(negedge clk);
    irq_lines = v;
    @(negedge clk);
  endtask

  task automatic t_reset;
    logic [DW-1:0] d;
    chk("R1 req", DW'(irq_req), '0);
    chk("R1 vec", DW'(irq_vec), '0);
    chk("R1 err", DW'(bus_err), '0);
    rd32(8'h00, d); chk("R1 mask", d, '0);
    rd32(8'h0C, d); chk("R1 nmi", d, '0);
    rd32(8'h10, d); chk("R1 fault", d, '0);
  endtask

  task automatic t_single;
    logic [DW-1:0] d;
    wr32(8'h00, 32'h3FFF_FFFF);
    set_lines(NL'(1) << 0);
    chk("R4 vec line0", DW'(irq_vec), 32'h31);
    chk("R4 req line0", DW'(irq_req), 32'h1);
    set_lines(NL'(1) << 29);
    chk("R4 vec line29", DW'(irq_vec), 32'h4E);
    set_lines(NL'(1) << 7);
    chk("R4 vec line7", DW'(irq_vec), 32'h38);
    rd32(8'h04, d); chk("R2 raw", d, 32'h80);
    rd32(8'h08, d); chk("R3 masked", d, 32'h80);
  endtask

  task automatic t_multi;
    set_lines((NL'(1) << 3) | (NL'(1) << 20));
    chk("R5 vec two", DW'(irq_vec), 32'h30);
    chk("R5 req two", DW'(irq_req), 32'h1);
    set_lines(NL'(32'h2000_0003));
    chk("R5 vec three", DW'(irq_vec), 32'h30);
  endtask

  task automatic t_none;
    logic [DW-1:0] d;
    set_lines('0);
    chk("R6 req", DW'(irq_req), '0);
    chk("R6 vec", DW'(irq_vec), '0);
    rd32(8'h04, d); chk("R2 raw cleared", d, '0);
  endtask

  task automatic t_mask;
    logic [DW-1:0] d;
    set_lines((NL'(1) << 5) | (NL'(1) << 9));
    chk("R5 before mask", DW'(irq_vec), 32'h30);
    wr32(8'h00, 32'h0000_0200);
    chk("R7 vec masked", DW'(irq_vec), 32'h3A);
    rd32(8'h08, d); chk("R3 masked after write", d, 32'h200);
    wr32(8'h00, 32'h0);
    chk("R7 req off", DW'(irq_req), '0);
    chk("R6 vec off", DW'(irq_vec), '0);
    wr32(8'h00, 32'hFFFF_FFFF);
    rd32(8'h00, d); chk("R7 mask readback", d, 32'hFFFF_FFFF);
  endtask

  task automatic t_nmi_fault;
    logic [DW-1:0] d;
    set_lines('0);
    wr32(8'h0C, 32'hDEAD_BEEF);
    wr32(8'h10, 32'h1234_5678);
    chk("R8 req unaffected", DW'(irq_req), '0);
    rd32(8'h0C, d); chk("R8 nmi", d, 32'hDEAD_BEEF);
    rd32(8'h10, d); chk("R8 fault", d, 32'h1234_5678);
  endtask

  task automatic t_readonly;
    logic [DW-1:0] d;
    set_lines(NL'(1) << 2);
    wr32(8'h04, 32'hFFFF_FFFF);
    wr32(8'h08, 32'hFFFF_FFFF);
    rd32(8'h04, d); chk("R9 raw kept", d, 32'h4);
    rd32(8'h08, d); chk("R9 masked kept", d, 32'h4);
    chk("R9 vec", DW'(irq_vec), 32'h33);
  endtask

  task automatic t_narrow;
    logic [DW-1:0] d; logic er;
    bus_acc(1'b0, 2'd0, 8'h0C, '0, d, er); chk("R10 byte read", d, '0);
    bus_acc(1'b0, 2'd1, 8'h00, '0, d, er); chk("R10 half read", d, '0);
    bus_acc(1'b1, 2'd1, 8'h00, 32'h0, d, er);
    bus_acc(1'b1, 2'd0, 8'h0C, 32'h0, d, er);
    rd32(8'h00, d); chk("R10 mask kept", d, 32'hFFFF_FFFF);
    rd32(8'h0C, d); chk("R10 nmi kept", d, 32'hDEAD_BEEF);
  endtask

  task automatic t_err;
    logic [DW-1:0] d; logic er;
    bus_acc(1'b1, 2'd2, 8'h14, 32'h0, d, er); chk("R11 err 0x14", DW'(er), 32'h1);
    @(negedge clk); chk("R11 err one cycle", DW'(bus_err), '0);
    bus_acc(1'b0, 2'd2, 8'h40, '0, d, er);
    chk("R11 err 0x40", DW'(er), 32'h1);
    chk("R11 rdata zero", d, '0);
    bus_acc(1'b1, 2'd2, 8'h02, 32'h0, d, er); chk("R11 err 0x02", DW'(er), 32'h1);
    rd32(8'h00, d); chk("R11 mask kept", d, 32'hFFFF_FFFF);
    @(negedge clk); chk("R12 rdata idle", bus_rdata, '0);
    chk("R11 vec kept", DW'(irq_vec), 32'h33);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_single;
    t_multi;
    t_none;
    t_mask;
    t_nmi_fault;
    t_readonly;
    t_narrow;
    t_err;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule